// File: doc/BRIEF.md
# Flash Program/Erase Status Word

This block keeps the eight-bit status word of an embedded flash program/erase engine, together with a small counter-based model of the engine. The model exists so the word can be exercised. Single-cycle strobes start a program or an erase, request a suspend, resume a paused operation, or clear the error flags. When an operation starts, the block samples the target-block lock flag and the programming-supply flag. It samples the injected verify-failure flags when the operation completes. The length of each operation and the delay before a suspend takes effect are parameters.

The word reaches the bus through a capture register. The active-low chip-select and read-enable inputs are first synchronized to the clock. The word is latched when both synchronized enables are low, which is the fall of whichever enable goes low last. It then holds until an enable rises. While an operation runs, a select output tells the read path to return the status word for any address.

Top module: `pe_status_top`

## Requirements
- R1: Bit 7 of the word reads 1 when the engine is idle or paused and 0 while an operation runs. `rd_status_sel` is 1 exactly while an operation runs. A program runs for PROG_CYCLES cycles and an erase for ERASE_CYCLES cycles, counted from the clock edge that accepts the start strobe.
- R2: A suspend during a running operation leaves bit 7 at 0 for SUSP_LAT more cycles. The engine then pauses: bit 7 reads 1, and bit 6 reads 1 for a paused erase or bit 2 reads 1 for a paused program. A resume clears that bit and the operation continues with the cycles it had left.
- R3: If an operation finishes before the suspend delay runs out, it completes normally and no suspend bit is set. A suspend strobe while idle is ignored.
- R4: A completed erase with `erase_vfail` high sets bit 5. A completed program with `prog_vfail` high sets bit 4. Both flags are sampled in the completion cycle.
- R5: `supply_ok` is sampled only when an operation starts. If it is low, bit 3 is set and the operation does not run.
- R6: A start with `blk_locked` high sets bit 1 and the operation does not run. A start with both conditions sets both bits 3 and 1.
- R7: Bits 5, 4, 3 and 1 are sticky. Only `cmd_clear` or reset drops them. While any of them is set, a start strobe is ignored: nothing runs and the word is unchanged.
- R8: Bit 0 always reads 0. After reset, `stat_q` is 0x00 until the first capture, and the first capture reads 0x80.
- R9: `stat_q` loads the live word when both synchronized enables become low. It holds while both stay low. An enable must rise and fall again before a newer word is visible.
- R10: Start strobes are ignored while an operation runs or is paused. A program strobe during an erase leaves the erase and its result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_prog | input | 1 | Start-program strobe |
| cmd_erase | input | 1 | Start-erase strobe |
| cmd_susp | input | 1 | Suspend request strobe |
| cmd_resume | input | 1 | Resume strobe |
| cmd_clear | input | 1 | Clear-errors strobe |
| blk_locked | input | 1 | Target block is locked, sampled at start |
| supply_ok | input | 1 | Programming supply valid, sampled at start |
| prog_vfail | input | 1 | Injected program verify failure, sampled at completion |
| erase_vfail | input | 1 | Injected erase verify failure, sampled at completion |
| ce_n | input | 1 | Active-low chip select, asynchronous |
| oe_n | input | 1 | Active-low read enable, asynchronous |
| stat_q | output | 8 | Captured status word |
| rd_status_sel | output | 1 | Read path must return the status word |

## Verification
A table drives program and erase starts under each mix of lock, supply and verify-failure inputs. The table tells apart a clean finish, a verify failure of each kind, and an abort on lock, on supply, or on both. It also shows that an aborted erase ignores its verify flag. Directed sequences suspend an erase, suspend a program, suspend just before completion, and suspend while idle, which separates the pause bits from normal completion. Further sequences check that errors block new starts until a clear, and that the capture register holds while the enables stay low and only updates after a toggle.

// File: rtl/pe_stat_pkg.sv
package pe_stat_pkg;

  // Engine sequencer states
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_RUN    = 2'd1,
    SQ_SPWAIT = 2'd2,
    SQ_PAUSED = 2'd3
  } sq_state_t;

  // Positions inside the status word
  localparam int unsigned BIT_READY  = 7;
  localparam int unsigned BIT_ESUSP  = 6;
  localparam int unsigned BIT_EFAIL  = 5;
  localparam int unsigned BIT_PFAIL  = 4;
  localparam int unsigned BIT_SUPPLY = 3;
  localparam int unsigned BIT_PSUSP  = 2;
  localparam int unsigned BIT_LOCK   = 1;

  // Sticky error register layout
  localparam int unsigned ERR_W    = 4;
  localparam int unsigned ERR_LOCK = 0;
  localparam int unsigned ERR_SUP  = 1;
  localparam int unsigned ERR_PF   = 2;
  localparam int unsigned ERR_EF   = 3;

endpackage

// File: rtl/pe_sync.sv
module pe_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = din;
      end else begin : g_rest
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= {W{RST_V}};
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pe_op_seq.sv
module pe_op_seq
  import pe_stat_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 8,
  parameter int unsigned ERASE_CYCLES = 24,
  parameter int unsigned SUSP_LAT     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_prog,
  input  logic cmd_erase,
  input  logic cmd_susp,
  input  logic cmd_resume,
  input  logic blk_locked,
  input  logic supply_ok,
  input  logic err_any,
  output logic busy,
  output logic paused,
  output logic op_erase,
  output logic abort_lock,
  output logic abort_sup,
  output logic done
);

  localparam int unsigned MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned SW   = $clog2(SUSP_LAT + 1);

  sq_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic          erase_q, erase_d;
  logic          start_req, start_en;

  assign start_req = cmd_prog | cmd_erase;
  assign start_en  = (st_q == SQ_IDLE) && start_req && !err_any;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    scnt_d     = scnt_q;
    erase_d    = erase_q;
    abort_lock = 1'b0;
    abort_sup  = 1'b0;
    done       = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start_en) begin
          if (!supply_ok || blk_locked) begin
            abort_sup  = !supply_ok;
            abort_lock = blk_locked;
          end else begin
            st_d    = SQ_RUN;
            erase_d = !cmd_prog;
            cnt_d   = cmd_prog ? CW'(PROG_CYCLES - 1) : CW'(ERASE_CYCLES - 1);
          end
        end
      end
      SQ_RUN: begin
        if (cnt_q == '0) begin
          done = 1'b1;
          st_d = SQ_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
          if (cmd_susp) begin
            st_d   = SQ_SPWAIT;
            scnt_d = SW'(SUSP_LAT - 1);
          end
        end
      end
      SQ_SPWAIT: begin
        if (cnt_q == '0) begin
          done = 1'b1;
          st_d = SQ_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
          if (scnt_q == '0) st_d = SQ_PAUSED;
          else              scnt_d = scnt_q - 1'b1;
        end
      end
      SQ_PAUSED: begin
        if (cmd_resume) st_d = SQ_RUN;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      scnt_q  <= '0;
      erase_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      scnt_q  <= scnt_d;
      erase_q <= erase_d;
    end
  end

  assign busy     = (st_q == SQ_RUN) || (st_q == SQ_SPWAIT);
  assign paused   = (st_q == SQ_PAUSED);
  assign op_erase = erase_q;

  // R1
  clean_start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && start_req && !err_any && supply_ok && !blk_locked) |=> busy);

  // R7
  err_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && err_any) |=> (st_q == SQ_IDLE));

  // R3
  idle_susp_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && !start_req && cmd_susp) |=> (st_q == SQ_IDLE));

  // R2
  resume_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && cmd_resume) |=> (busy && $stable(cnt_q)));

  // R10
  op_kind_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_IDLE) |=> $stable(erase_q));

endmodule

// File: rtl/pe_flag_core.sv
module pe_flag_core
  import pe_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_clear,
  input  logic       busy,
  input  logic       paused,
  input  logic       op_erase,
  input  logic       abort_lock,
  input  logic       abort_sup,
  input  logic       done,
  input  logic       prog_vfail,
  input  logic       erase_vfail,
  output logic       err_any,
  output logic [7:0] live_word
);

  logic [ERR_W-1:0] err_q, err_d, err_set;

  always_comb begin
    err_set           = '0;
    err_set[ERR_LOCK] = abort_lock;
    err_set[ERR_SUP]  = abort_sup;
    err_set[ERR_PF]   = done && !op_erase && prog_vfail;
    err_set[ERR_EF]   = done &&  op_erase && erase_vfail;
    if (cmd_clear) err_d = '0;
    else           err_d = err_q | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

  assign err_any = |err_q;

  always_comb begin
    live_word             = 8'h00;
    live_word[BIT_READY]  = !busy;
    live_word[BIT_ESUSP]  = paused && op_erase;
    live_word[BIT_EFAIL]  = err_q[ERR_EF];
    live_word[BIT_PFAIL]  = err_q[ERR_PF];
    live_word[BIT_SUPPLY] = err_q[ERR_SUP];
    live_word[BIT_PSUSP]  = paused && !op_erase;
    live_word[BIT_LOCK]   = err_q[ERR_LOCK];
  end

  // R7
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_clear |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R7
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> (err_q == '0));

  // R2
  susp_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({live_word[BIT_ESUSP], live_word[BIT_PSUSP]}) && !(busy && paused));

endmodule

// File: rtl/pe_bus_capture.sv
module pe_bus_capture #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic [7:0] live_word,
  output logic [7:0] stat_q
);

  logic [1:0] en_s;
  logic       rd_act, rd_act_q, cap_en;
  logic [7:0] stat_d;

  pe_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_en_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ce_n, oe_n}),
    .dout (en_s)
  );

  assign rd_act = !en_s[1] && !en_s[0];
  assign cap_en = rd_act && !rd_act_q;

  always_comb begin
    stat_d = stat_q;
    if (cap_en) stat_d = live_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      stat_q   <= 8'h00;
    end else begin
      rd_act_q <= rd_act;
      stat_q   <= stat_d;
    end
  end

  // R9
  hold_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && rd_act_q) |=> $stable(stat_q));

  // R9
  capture_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && !rd_act_q) |=> (stat_q == $past(live_word)));

endmodule

// File: rtl/pe_status_top.sv
module pe_status_top #(
  parameter int unsigned PROG_CYCLES  = 8,
  parameter int unsigned ERASE_CYCLES = 24,
  parameter int unsigned SUSP_LAT     = 4,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_prog,
  input  logic       cmd_erase,
  input  logic       cmd_susp,
  input  logic       cmd_resume,
  input  logic       cmd_clear,
  input  logic       blk_locked,
  input  logic       supply_ok,
  input  logic       prog_vfail,
  input  logic       erase_vfail,
  input  logic       ce_n,
  input  logic       oe_n,
  output logic [7:0] stat_q,
  output logic       rd_status_sel
);

  logic       rst_sync_n;
  logic [0:0] rst_chain;
  logic       busy, paused, op_erase, abort_lock, abort_sup, done, err_any;
  logic [7:0] live_word;

  pe_sync #(.W(1), .STAGES(2), .RST_V(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (1'b1),
    .dout (rst_chain)
  );
  assign rst_sync_n = rst_chain[0];

  pe_op_seq #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .SUSP_LAT    (SUSP_LAT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_prog  (cmd_prog),
    .cmd_erase (cmd_erase),
    .cmd_susp  (cmd_susp),
    .cmd_resume(cmd_resume),
    .blk_locked(blk_locked),
    .supply_ok (supply_ok),
    .err_any   (err_any),
    .busy      (busy),
    .paused    (paused),
    .op_erase  (op_erase),
    .abort_lock(abort_lock),
    .abort_sup (abort_sup),
    .done      (done)
  );

  pe_flag_core u_flags (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_clear  (cmd_clear),
    .busy       (busy),
    .paused     (paused),
    .op_erase   (op_erase),
    .abort_lock (abort_lock),
    .abort_sup  (abort_sup),
    .done       (done),
    .prog_vfail (prog_vfail),
    .erase_vfail(erase_vfail),
    .err_any    (err_any),
    .live_word  (live_word)
  );

  pe_bus_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .live_word(live_word),
    .stat_q   (stat_q)
  );

  assign rd_status_sel = busy;

  // R8
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(stat_q[0] == 1'b0) |-> (stat_q[0] == 1'b0));

endmodule

// File: tb/tb_pe_status_top.sv
`timescale 1ns/1ps
module tb_pe_status_top;

  localparam int unsigned PROG  = 8;
  localparam int unsigned ERASE = 24;
  localparam int unsigned SLAT  = 4;
  localparam int unsigned SYNC  = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_prog, cmd_erase, cmd_susp, cmd_resume, cmd_clear;
  logic blk_locked, supply_ok, prog_vfail, erase_vfail, ce_n, oe_n;
  logic [7:0] stat_q;
  logic rd_status_sel;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  pe_status_top #(
    .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE), .SUSP_LAT(SLAT), .SYNC_STAGES(SYNC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
    .cmd_susp(cmd_susp), .cmd_resume(cmd_resume), .cmd_clear(cmd_clear),
    .blk_locked(blk_locked), .supply_ok(supply_ok), .prog_vfail(prog_vfail),
    .erase_vfail(erase_vfail), .ce_n(ce_n), .oe_n(oe_n), .stat_q(stat_q),
    .rd_status_sel(rd_status_sel)
  );

  // Vector: {is_erase, locked, supply_ok, vfail, expected word}
  localparam logic [11:0] VECS [8] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h80},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h80},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h90},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'hA0},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h82},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h88},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h8A},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h82}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic p, input logic e, input logic s,
                       input logic r, input logic c);
    @(negedge clk);
    cmd_prog = p; cmd_erase = e; cmd_susp = s; cmd_resume = r; cmd_clear = c;
    @(negedge clk);
    cmd_prog = 0; cmd_erase = 0; cmd_susp = 0; cmd_resume = 0; cmd_clear = 0;
  endtask

  task automatic bus_read(output logic [7:0] v);
    ce_n = 0; oe_n = 0;
    repeat (SYNC + 2) @(negedge clk);
    v = stat_q;
    ce_n = 1; oe_n = 1;
    repeat (SYNC + 1) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && rd_status_sel; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    cmd_prog = 0; cmd_erase = 0; cmd_susp = 0; cmd_resume = 0; cmd_clear = 0;
    blk_locked = 0; supply_ok = 1; prog_vfail = 0; erase_vfail = 0;
    ce_n = 1; oe_n = 1; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R8 reset state and first capture
    check("R8 reset stat_q", stat_q, 8'h00);
    check("R1 reset sel", {7'd0, rd_status_sel}, 8'h00);
    bus_read(v);
    check("R8 first read", v, 8'h80);

    // Table of result patterns (R4 R5 R6)
    for (int k = 0; k < 8; k++) begin
      issue(0, 0, 0, 0, 1);
      blk_locked  = VECS[k][10];
      supply_ok   = VECS[k][9];
      prog_vfail  = VECS[k][8];
      erase_vfail = VECS[k][8];
      issue(!VECS[k][11], VECS[k][11], 0, 0, 0);
      wait_idle();
      blk_locked = 0; supply_ok = 1; prog_vfail = 0; erase_vfail = 0;
      bus_read(v);
      check($sformatf("R4 R5 R6 vector %0d", k), v, VECS[k][7:0]);
    end

    // R7 sticky error (lock bit 1 left from last vector) blocks a clean start
    issue(1, 0, 0, 0, 0);
    check("R7 start blocked sel", {7'd0, rd_status_sel}, 8'h00);
    bus_read(v);
    check("R7 word unchanged", v, 8'h82);
    issue(0, 0, 0, 0, 1);
    bus_read(v);
    check("R7 clear drops errors", v, 8'h80);

    // R1 program length exact
    issue(1, 0, 0, 0, 0);
    for (int i = 0; i < PROG; i++) begin
      check("R1 busy during program", {7'd0, rd_status_sel}, 8'h01);
      @(negedge clk);
    end
    check("R1 idle after program", {7'd0, rd_status_sel}, 8'h00);

    // R1 read during erase shows busy; R10 program strobe ignored
    prog_vfail = 1;
    issue(0, 1, 0, 0, 0);
    bus_read(v);
    check("R1 busy word", v, 8'h00);
    issue(1, 0, 0, 0, 0);
    wait_idle();
    prog_vfail = 0;
    bus_read(v);
    check("R10 start during erase ignored", v, 8'h80);

    // R9 hold while enables low, update after toggle
    ce_n = 0; oe_n = 0;
    repeat (SYNC + 2) @(negedge clk);
    check("R9 capture idle", stat_q, 8'h80);
    issue(0, 1, 0, 0, 0);
    check("R9 held during op", stat_q, 8'h80);
    ce_n = 1; oe_n = 1;
    repeat (SYNC + 1) @(negedge clk);
    bus_read(v);
    check("R9 update after toggle", v, 8'h00);
    wait_idle();

    // R2 erase suspend
    issue(0, 1, 0, 0, 0);
    repeat (2) @(negedge clk);
    issue(0, 0, 1, 0, 0);
    for (int i = 0; i < SLAT; i++) begin
      check("R2 busy in suspend delay", {7'd0, rd_status_sel}, 8'h01);
      @(negedge clk);
    end
    check("R2 paused not busy", {7'd0, rd_status_sel}, 8'h00);
    bus_read(v);
    check("R2 erase paused word", v, 8'hC0);
    issue(0, 0, 0, 1, 0);
    check("R2 resume runs", {7'd0, rd_status_sel}, 8'h01);
    wait_idle();
    bus_read(v);
    check("R2 erase finished", v, 8'h80);

    // R2 program suspend
    issue(1, 0, 0, 0, 0);
    issue(0, 0, 1, 0, 0);
    repeat (SLAT + 1) @(negedge clk);
    bus_read(v);
    check("R2 program paused word", v, 8'h84);
    issue(0, 0, 0, 1, 0);
    wait_idle();
    bus_read(v);
    check("R2 program finished", v, 8'h80);

    // R3 suspend too late: completes
    issue(1, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    issue(0, 0, 1, 0, 0);
    wait_idle();
    bus_read(v);
    check("R3 late suspend completes", v, 8'h80);

    // R3 suspend while idle ignored
    issue(0, 0, 1, 0, 0);
    check("R3 idle suspend sel", {7'd0, rd_status_sel}, 8'h00);
    bus_read(v);
    check("R3 idle suspend word", v, 8'h80);

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule